// File: doc/BRIEF.md
# MII Receive Framer with Word Stream Output

This block turns the nibble stream of a 100 Mb/s media-independent receive interface into a stream of 32-bit words in the system clock domain. On the receive clock it drops the preamble and start delimiter and rebuilds bytes from nibble pairs. It keeps a running CRC-32 over the frame and holds back the last four bytes, so the frame check sequence never reaches the output. Payload bytes are packed into words, and each word goes through a dual-clock FIFO together with its framing flags.

On the system side a consumer takes words under a valid/ready handshake. The first word of a frame carries start-of-packet. The last word carries end-of-packet, a 2-bit count of unused bytes and an 8-bit status that reports a good frame, a CRC failure or a truncated frame. A frame is truncated when the PHY signals a receive error or when the FIFO runs out of room. In both cases the frame is still closed with end-of-packet.

Top module: `mii_rx_stream`

## Requirements
- R1: Nibbles of value 0x5 are skipped. Payload starts after the first 0xD nibble that directly follows a 0x5, for any preamble length from one nibble up.
- R2: Each byte is built low nibble first. Within a word the earliest byte sits in bits 31:24 and the latest in bits 7:0.
- R3: The four trailing check bytes are removed, so a 64-byte frame yields 60 payload bytes in 15 words.
- R4: Start-of-packet is set only on the first word of a frame and end-of-packet only on the last. On the last word the empty field gives the number of unused low-order bytes, with 0 meaning all four are used. The empty field is 0 on every other word.
- R5: The status is 0x80 when the CRC residue over the frame including its check bytes is correct, 0x85 when it is not, and 0x00 on words without end-of-packet.
- R6: A receive error while a frame is in progress stops byte intake for that frame. The bytes already taken, minus the four still held back, are emitted and the frame is closed with status 0x89.
- R7: When a completed word meets a FIFO with one free slot left, that word is written with end-of-packet and status 0x89 and the rest of the frame is dropped. A frame that meets a full FIFO at its first word produces no output at all.
- R8: While valid is high and ready is low, the presented word and its flags stay unchanged.
- R9: Valid is low during reset and while the FIFO is empty.
- R10: If data-valid rises and any nibble other than 0x5 appears before the 0xD delimiter, the whole frame is ignored.
- R11: A leftover odd nibble at the end of a frame is discarded and does not change the data or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk_i | input | 1 | Receive clock from the PHY |
| sys_clk_i | input | 1 | System clock for the output stream |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| mii_d_i | input | 4 | Receive nibble |
| mii_dv_i | input | 1 | Receive data-valid |
| mii_er_i | input | 1 | Receive error |
| out_data_o | output | 32 | Payload word, earliest byte in bits 31:24 |
| out_valid_o | output | 1 | Word available |
| out_sop_o | output | 1 | First word of a frame |
| out_eop_o | output | 1 | Last word of a frame |
| out_empty_o | output | 2 | Unused low bytes in the last word |
| out_status_o | output | 8 | Frame status on the last word |
| out_ready_i | input | 1 | Consumer accepts the word |

## Verification
A payload byte reaches the FIFO only after four more bytes have arrived and its word has filled, so it shows up at least eight receive clocks after it enters. The closing word is written three receive clocks after data-valid falls. The write pointer then needs two to three system clocks to cross into the read domain. For each frame the bench waits 300 system clocks after data-valid drops, which is far beyond that worst case, before it compares the captured words. Ready is set and each beat is recorded at the same falling system edge, so a beat is counted exactly when the rising edge that follows transfers it.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam logic [7:0]  ST_NONE  = 8'h00;
  localparam logic [7:0]  ST_GOOD  = 8'h80;
  localparam logic [7:0]  ST_CRC   = 8'h85;
  localparam logic [7:0]  ST_TRUNC = 8'h89;
  // reflected CRC-32: residue after data plus complemented FCS
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef struct packed {
    logic        sop;
    logic        eop;
    logic [1:0]  empty;
    logic [7:0]  status;
    logic [31:0] data;
  } beat_t;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/mii_rx_nibble.sv
module mii_rx_nibble (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] d_i,
  input  logic       dv_i,
  input  logic       er_i,
  output logic       start_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       end_o,
  output logic       err_o
);
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA, S_SKIP} st_e;
  st_e        st_q;
  logic [3:0] d_q, lo_q;
  logic       dv_q, er_q, half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0; dv_q <= 1'b0; er_q <= 1'b0;
      st_q <= S_IDLE; lo_q <= '0; half_q <= 1'b0;
      start_o <= 1'b0; byte_vld_o <= 1'b0; byte_o <= '0; end_o <= 1'b0; err_o <= 1'b0;
    end else begin
      d_q <= d_i; dv_q <= dv_i; er_q <= er_i;
      start_o <= 1'b0; byte_vld_o <= 1'b0; end_o <= 1'b0; err_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (dv_q) st_q <= (d_q == 4'h5) ? S_PRE : S_SKIP;
        S_PRE: begin
          if (!dv_q) st_q <= S_IDLE;
          else if (d_q == 4'hD) begin
            st_q <= S_DATA; start_o <= 1'b1; half_q <= 1'b0;
          end else if (d_q != 4'h5) st_q <= S_SKIP;
        end
        S_DATA: begin
          if (!dv_q) begin
            end_o <= 1'b1; st_q <= S_IDLE;  // odd trailing nibble is dropped
          end else begin
            if (er_q) err_o <= 1'b1;
            if (!half_q) begin
              lo_q <= d_q; half_q <= 1'b1;
            end else begin
              byte_o <= {d_q, lo_q}; byte_vld_o <= 1'b1; half_q <= 1'b0;
            end
          end
        end
        default: if (!dv_q) st_q <= S_IDLE;
      endcase
    end
  end

  a_r2_byte_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
endmodule

// File: rtl/mii_rx_pack.sv
module mii_rx_pack
  import mii_rx_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          end_i,
  input  logic          err_i,
  input  logic [AW:0]   wr_free_i,
  output logic          wr_en_o,
  output beat_t         wr_beat_o
);
  logic [31:0] crc_q, dly_q, wbuf_q, lane;
  logic [2:0]  dcnt_q, wcnt_q;
  logic        sop_done_q, trunc_q, done_q, last_slot, fifo_full;
  logic [7:0]  pay;

  assign pay       = dly_q[7:0];
  assign lane      = {pay, 24'd0} >> {wcnt_q[1:0], 3'b000};
  assign last_slot = (wr_free_i == {{AW{1'b0}}, 1'b1});
  assign fifo_full = (wr_free_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '1; dly_q <= '0; wbuf_q <= '0; dcnt_q <= '0; wcnt_q <= '0;
      sop_done_q <= 1'b0; trunc_q <= 1'b0; done_q <= 1'b1;
      wr_en_o <= 1'b0; wr_beat_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        crc_q <= '1; dcnt_q <= '0; wcnt_q <= '0; wbuf_q <= '0;
        sop_done_q <= 1'b0; trunc_q <= 1'b0; done_q <= 1'b0;
      end else if (!done_q) begin
        if (err_i) trunc_q <= 1'b1;
        else if (byte_vld_i && !trunc_q) begin
          crc_q <= crc_byte(crc_q, byte_i);
          dly_q <= {byte_i, dly_q[31:8]};
          if (dcnt_q != 3'd4) dcnt_q <= dcnt_q + 3'd1;
          else if (wcnt_q != 3'd4) begin
            wbuf_q <= wbuf_q | lane;
            wcnt_q <= wcnt_q + 3'd1;
          end else if (fifo_full) done_q <= 1'b1;  // no room even for the first word
          else begin
            wr_en_o   <= 1'b1;
            wr_beat_o <= '{sop: !sop_done_q, eop: last_slot, empty: 2'd0,
                           status: last_slot ? ST_TRUNC : ST_NONE, data: wbuf_q};
            sop_done_q <= 1'b1;
            wbuf_q     <= {pay, 24'd0};
            wcnt_q     <= 3'd1;
            if (last_slot) done_q <= 1'b1;
          end
        end
        if (end_i) begin
          done_q <= 1'b1;
          if (wcnt_q != 3'd0 && !fifo_full) begin
            wr_en_o   <= 1'b1;
            wr_beat_o <= '{sop: !sop_done_q, eop: 1'b1, empty: 2'd0 - wcnt_q[1:0],
                           status: trunc_q ? ST_TRUNC : ((crc_q == CRC_RESIDUE) ? ST_GOOD : ST_CRC),
                           data: wbuf_q};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mii_rx_afifo.sv
module mii_rx_afifo #(
  parameter int unsigned W  = 44,
  parameter int unsigned AW = 11
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [AW:0]   wr_free_o,
  input  logic          rclk_i,
  output logic          rd_valid_o,
  output logic [W-1:0]  rd_data_o,
  input  logic          rd_ready_i
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin_q, wgray_q, rgray_w1, rgray_w2, wbin_n;
  logic [AW:0]  rbin_q, rgray_q, wgray_r1, wgray_r2, rbin_n;

  assign wbin_n    = wbin_q + 1'b1;
  assign rbin_n    = rbin_q + 1'b1;
  assign wr_free_o = DEPTH_V - (wbin_q - g2b(rgray_w2));

  always_ff @(posedge wclk_i) if (wr_en_i) mem[wbin_q[AW-1:0]] <= wr_data_i;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q <= '0; wgray_q <= '0; rgray_w1 <= '0; rgray_w2 <= '0;
    end else begin
      rgray_w1 <= rgray_q; rgray_w2 <= rgray_w1;
      if (wr_en_i) begin
        wbin_q  <= wbin_n;
        wgray_q <= wbin_n ^ (wbin_n >> 1);
      end
    end
  end

  assign rd_valid_o = (rgray_q != wgray_r2);
  assign rd_data_o  = mem[rbin_q[AW-1:0]];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q <= '0; rgray_q <= '0; wgray_r1 <= '0; wgray_r2 <= '0;
    end else begin
      wgray_r1 <= wgray_q; wgray_r2 <= wgray_r1;
      if (rd_valid_o && rd_ready_i) begin
        rbin_q  <= rbin_n;
        rgray_q <= rbin_n ^ (rbin_n >> 1);
      end
    end
  end

  a_r7_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_en_i |-> wr_free_o != '0);
  a_r8_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));
endmodule

// File: rtl/mii_rx_stream.sv
module mii_rx_stream
  import mii_rx_pkg::*;
#(
  parameter int unsigned FIFO_WORDS = 2048
) (
  input  logic        rx_clk_i,
  input  logic        sys_clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  mii_d_i,
  input  logic        mii_dv_i,
  input  logic        mii_er_i,
  output logic [31:0] out_data_o,
  output logic        out_valid_o,
  output logic        out_sop_o,
  output logic        out_eop_o,
  output logic [1:0]  out_empty_o,
  output logic [7:0]  out_status_o,
  input  logic        out_ready_i
);
  localparam int unsigned AW = $clog2(FIFO_WORDS);
  localparam int unsigned BW = $bits(beat_t);

  logic        start, byte_vld, frm_end, frm_err, wr_en;
  logic [7:0]  byte_d;
  logic [AW:0] wr_free;
  beat_t       wr_beat, rd_beat;
  logic [BW-1:0] rd_bits;

  mii_rx_nibble u_nib (
    .clk_i(rx_clk_i), .rst_ni(rst_ni), .d_i(mii_d_i), .dv_i(mii_dv_i), .er_i(mii_er_i),
    .start_o(start), .byte_vld_o(byte_vld), .byte_o(byte_d), .end_o(frm_end), .err_o(frm_err)
  );

  mii_rx_pack #(.AW(AW)) u_pack (
    .clk_i(rx_clk_i), .rst_ni(rst_ni), .start_i(start), .byte_vld_i(byte_vld),
    .byte_i(byte_d), .end_i(frm_end), .err_i(frm_err), .wr_free_i(wr_free),
    .wr_en_o(wr_en), .wr_beat_o(wr_beat)
  );

  mii_rx_afifo #(.W(BW), .AW(AW)) u_fifo (
    .wclk_i(rx_clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_beat),
    .wr_free_o(wr_free), .rclk_i(sys_clk_i), .rd_valid_o(out_valid_o),
    .rd_data_o(rd_bits), .rd_ready_i(out_ready_i)
  );

  assign rd_beat      = beat_t'(rd_bits);
  assign out_data_o   = rd_beat.data;
  assign out_sop_o    = rd_beat.sop;
  assign out_eop_o    = rd_beat.eop;
  assign out_empty_o  = rd_beat.empty;
  assign out_status_o = rd_beat.status;

  a_r5_status_on_eop: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    out_valid_o && !out_eop_o |-> out_status_o == ST_NONE);
  a_r4_empty_on_eop: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    out_valid_o && !out_eop_o |-> out_empty_o == 2'd0);
endmodule

// File: tb/sim_mii_rx_stream.sv
module sim_mii_rx_stream;
  logic       rx_clk = 1'b0, sys_clk = 1'b0, rst_ni = 1'b0;
  logic [3:0] mii_d = '0;
  logic       mii_dv = 1'b0, mii_er = 1'b0, out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_valid, out_sop, out_eop;
  logic [1:0]  out_empty;
  logic [7:0]  out_status;

  always #10 sys_clk = ~sys_clk;   // 50 MHz
  always #20 rx_clk  = ~rx_clk;    // 25 MHz nibble clock

  mii_rx_stream #(.FIFO_WORDS(16)) u0 (
    .rx_clk_i(rx_clk), .sys_clk_i(sys_clk), .rst_ni(rst_ni),
    .mii_d_i(mii_d), .mii_dv_i(mii_dv), .mii_er_i(mii_er),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_sop_o(out_sop),
    .out_eop_o(out_eop), .out_empty_o(out_empty), .out_status_o(out_status),
    .out_ready_i(out_ready)
  );

  // {preamble nibbles[31:28], flags[27:24] (0 bad crc,1 rx err,2 odd nibble,3 backpressure), seed[23:16], len[15:0]}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    32'hF001_003C, 32'hF002_003D, 32'h7003_003E, 32'h1004_003F, 32'hF105_0040,
    32'hF806_0061, 32'hF407_002E, 32'hF208_0050, 32'h3909_0005
  };

  int checks = 0, fails = 0, rmode = 0, cyc = 0, cap_n = 0;
  bit finished = 0;
  logic [31:0] cap_d  [512];
  logic        cap_s  [512];
  logic        cap_e  [512];
  logic [1:0]  cap_m  [512];
  logic [7:0]  cap_st [512];

  always @(negedge sys_clk) begin
    cyc = cyc + 1;
    out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? ((cyc % 3) != 0) : 1'b0;
    if (rst_ni && out_valid && out_ready && cap_n < 512) begin
      cap_d[cap_n] = out_data; cap_s[cap_n] = out_sop; cap_e[cap_n] = out_eop;
      cap_m[cap_n] = out_empty; cap_st[cap_n] = out_status;
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [7:0] pb(int seed, int i);
    return 8'((seed * 37 + i * 11) & 255);
  endfunction

  function automatic logic [31:0] crc_upd(logic [31:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) c = (c[0] ^ b[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_frame(int pre, int len, int seed, bit bad, bit er, bit odd, bit badpre);
    logic [7:0]  fb [264];
    logic [31:0] c;
    int nib;
    c = '1;
    for (int i = 0; i < len; i++) begin fb[i] = pb(seed, i); c = crc_upd(c, fb[i]); end
    c = ~c;
    fb[len] = c[7:0] ^ {7'd0, bad}; fb[len+1] = c[15:8]; fb[len+2] = c[23:16]; fb[len+3] = c[31:24];
    nib = 2 * (len + 4);
    @(negedge rx_clk);
    mii_dv = 1'b1;
    for (int p = 0; p < pre; p++) begin
      mii_d = (badpre && p == 2) ? 4'h3 : 4'h5;
      @(negedge rx_clk);
    end
    mii_d = 4'hD;
    @(negedge rx_clk);
    for (int n = 0; n < nib + (odd ? 1 : 0); n++) begin
      if (n >= nib) mii_d = 4'hA;
      else mii_d = n[0] ? fb[n/2][7:4] : fb[n/2][3:0];
      mii_er = er && (n == len);
      @(negedge rx_clk);
    end
    mii_dv = 1'b0; mii_er = 1'b0; mii_d = '0;
    repeat (24) @(negedge rx_clk);
  endtask

  task automatic check_frame(int base, int seed, int pl, logic [7:0] st,
                             string rcnt, string rdat, string rst);
    int nw;
    logic [31:0] mask, exp;
    nw = (pl + 3) / 4;
    chk(cap_n - base == nw, rcnt, cap_n - base, nw);
    if (cap_n - base == nw) begin
      for (int k = 0; k < nw; k++) begin
        mask = '0; exp = '0;
        for (int m = 0; m < 4; m++)
          if (4*k + m < pl) begin
            mask[31-8*m -: 8] = 8'hFF;
            exp[31-8*m -: 8]  = pb(seed, 4*k + m);
          end
        chk((cap_d[base+k] & mask) == exp, rdat, cap_d[base+k] & mask, exp);
        chk(cap_s[base+k] == (k == 0) && cap_e[base+k] == (k == nw-1), "R4 sop/eop",
            {cap_s[base+k], cap_e[base+k]}, {k == 0, k == nw-1});
        if (k == nw-1) begin
          chk(cap_m[base+k] == 2'((4 - pl % 4) % 4), "R4 empty", cap_m[base+k], (4 - pl % 4) % 4);
          chk(cap_st[base+k] == st, rst, cap_st[base+k], st);
        end else
          chk(cap_st[base+k] == 8'h00, "R5 mid status", cap_st[base+k], 0);
      end
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    int base;
    repeat (5) @(negedge sys_clk);
    chk(!out_valid, "R9 valid in reset", out_valid, 0);
    rst_ni = 1'b1;
    repeat (10) @(negedge sys_clk);
    chk(!out_valid, "R9 valid after reset", out_valid, 0);

    for (int v = 0; v < NV; v++) begin
      int pre, len, seed, pl;
      bit bad, er, odd, bp;
      logic [7:0] st;
      pre = int'(VEC[v][31:28]); bad = VEC[v][24]; er = VEC[v][25]; odd = VEC[v][26];
      bp = VEC[v][27]; seed = int'(VEC[v][23:16]); len = int'(VEC[v][15:0]);
      pl = er ? (len / 2 - 4) : len;
      st = er ? 8'h89 : (bad ? 8'h85 : 8'h80);
      rmode = bp ? 1 : 0;
      base = cap_n;
      send_frame(pre, len + 4 - 4, seed, bad, er, odd, 1'b0);
      repeat (300) @(negedge sys_clk);
      rmode = 0;
      check_frame(base, seed, pl, st,
                  (pre < 15) ? "R1 short preamble count" : "R3 FCS stripped count",
                  bp ? "R8 data under backpressure" : (odd ? "R11 odd nibble data" : "R2 byte order"),
                  er ? "R6 rx error status" : "R5 frame status");
    end

    // R10: stray nibble inside the preamble drops the frame
    base = cap_n;
    send_frame(6, 20, 8'h30, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (200) @(negedge sys_clk);
    chk(cap_n == base, "R10 bad preamble ignored", cap_n - base, 0);

    // R7: fill the 16-entry FIFO with ready held low, then a frame that finds it full
    rmode = 2;
    base = cap_n;
    send_frame(15, 100, 8'h21, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(15, 20, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (100) @(negedge sys_clk);
    chk(cap_n == base, "R8 nothing taken while ready low", cap_n - base, 0);
    chk(out_valid, "R8 valid held while ready low", out_valid, 1);
    rmode = 0;
    repeat (200) @(negedge sys_clk);
    check_frame(base, 8'h21, 64, 8'h89, "R7 fifo full count", "R7 fifo full data", "R7 fifo full status");

    base = cap_n;
    send_frame(15, 30, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (300) @(negedge sys_clk);
    check_frame(base, 8'h40, 30, 8'h80, "R7 recovery count", "R2 recovery data", "R5 recovery status");

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule